// File: doc/BRIEF.md
# Packet Buffer Pool Manager with Fan-out Counting

This block owns the set of fixed-size packet buffers of a switch and hands out their indices. When a packet starts arriving, the receive side raises an allocate request and gets a buffer index back in the same cycle, or a no-buffer indication if every buffer is in use. The block does not store packet data. It only tracks which indices are free and how many more transmissions each occupied buffer still has to serve.

A buffer that is handed out starts with a remaining-transmission count of one, which suits a packet sent to a single port. When the forwarding logic finds that a packet goes to several ports, it overwrites that count with the number of destinations. Each port reports the end of its transmission with a decrement command, and the buffer goes back to the pool when the last destination is done. A drop command returns a buffer at once, whatever its count. Freed indices join the tail of a FIFO, so they are reused in the order they were released. A command that names a buffer that is not in use, or that sets a count of zero, raises a sticky error flag and changes nothing.

Top module: `pbuf_mgr`

## Requirements
- R1: After reset all NUM_BUF buffers are free, and successive allocations return indices 0, 1, 2, ... in increasing order. Later, freed indices are handed out again in the order in which they were freed.
- R2: While `alloc_req` is high and a buffer is available, `alloc_gnt` is high in the same cycle and `alloc_idx` carries the index. That buffer is then in use with a remaining count of 1.
- R3: While `alloc_req` is high and no buffer is available, `alloc_nobuf` is high, `alloc_gnt` is low and no index is consumed. Both outputs are low when `alloc_req` is low.
- R4: A set command (`cmd_op` = 2'b01) on an in-use buffer with a nonzero `cmd_cnt` replaces the remaining count of that buffer with `cmd_cnt`.
- R5: A decrement command (`cmd_op` = 2'b10) on an in-use buffer lowers its remaining count by one. When the count was 1, the buffer is freed and its index is appended to the tail of the free order.
- R6: A drop command (`cmd_op` = 2'b11) on an in-use buffer frees it at once, whatever its remaining count. `cmd_op` = 2'b00 does nothing.
- R7: When the pool is empty and a command frees a buffer in the same cycle as an allocate request, the freed index is granted directly to the request.
- R8: A set, decrement or drop command that names a buffer which is not in use, or a set command with a count of 0, leaves every count and the free order unchanged. It sets `err_flag` from the next cycle on.
- R9: `err_flag` stays high until reset and is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Receive side asks for a buffer this cycle |
| alloc_gnt | output | 1 | A buffer is granted this cycle |
| alloc_idx | output | IDX_W | Granted buffer index (0 when not granted) |
| alloc_nobuf | output | 1 | Request refused, no buffer available |
| cmd_vld | input | 1 | Command valid |
| cmd_op | input | 2 | 00 none, 01 set count, 10 decrement, 11 drop |
| cmd_idx | input | IDX_W | Buffer the command applies to |
| cmd_cnt | input | CNT_W | New remaining count for a set command |
| err_flag | output | 1 | Sticky error on an illegal command |

## Verification
Allocation and release can fall in the same cycle. The bench runs an allocate together with a drop or a final decrement in three situations: with buffers still in the pool, where the head is granted and the freed index goes to the tail; with the pool empty, where the freed index must be granted directly; and with a command aimed at the very index being granted, which must count as an error because that buffer was free before the edge. Each of these cases is judged by the granted index in that cycle and by the order of the following grants, both compared against a reference free-list model.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;
   typedef enum logic [1:0] {
      OP_NONE = 2'b00,
      OP_SET  = 2'b01,
      OP_DEC  = 2'b10,
      OP_DROP = 2'b11
   } pbuf_op_e;
endpackage

// File: rtl/pbuf_free_fifo.sv
module pbuf_free_fifo #(
   parameter int NUM_BUF = 16,
   parameter int IDX_W   = $clog2(NUM_BUF)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [IDX_W-1:0] push_idx,
   input  logic             pop,
   output logic [IDX_W-1:0] head_idx,
   output logic             empty
);
   localparam int LVL_W = $clog2(NUM_BUF + 1);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BUF - 1);

   logic [IDX_W-1:0] mem_q [NUM_BUF];
   logic [IDX_W-1:0] rd_q, wr_q;
   logic [LVL_W-1:0] lvl_q;
   logic             full;

   assign empty    = (lvl_q == '0);
   assign full     = (lvl_q == LVL_W'(NUM_BUF));
   assign head_idx = mem_q[rd_q];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_BUF; i++) mem_q[i] <= IDX_W'(i);
         rd_q  <= '0;
         wr_q  <= '0;
         lvl_q <= LVL_W'(NUM_BUF);
      end else begin
         if (push) begin
            mem_q[wr_q] <= push_idx;
            wr_q        <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
         end
         if (pop) rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
         if (push && !pop)      lvl_q <= lvl_q + 1'b1;
         else if (pop && !push) lvl_q <= lvl_q - 1'b1;
      end
   end

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !(push && !pop));
   // R3
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !pop);
endmodule

// File: rtl/pbuf_refcnt.sv
module pbuf_refcnt
   import pbuf_pkg::*;
#(
   parameter int NUM_BUF = 16,
   parameter int CNT_W   = 5,
   parameter int IDX_W   = $clog2(NUM_BUF)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_vld,
   input  pbuf_op_e         cmd_op,
   input  logic [IDX_W-1:0] cmd_idx,
   input  logic [CNT_W-1:0] cmd_cnt,
   input  logic             take,
   input  logic [IDX_W-1:0] take_idx,
   output logic             rel_vld,
   output logic [IDX_W-1:0] rel_idx,
   output logic             err_flag
);
   logic [NUM_BUF-1:0] inuse_q;
   logic [CNT_W-1:0]   cnt_q [NUM_BUF];
   logic               act, bad, good;

   assign act     = cmd_vld && (cmd_op != OP_NONE);
   assign bad     = act && (!inuse_q[cmd_idx] ||
                            (cmd_op == OP_SET && cmd_cnt == '0));
   assign good    = act && !bad;
   assign rel_vld = good && (cmd_op == OP_DROP ||
                             (cmd_op == OP_DEC && cnt_q[cmd_idx] == CNT_W'(1)));
   assign rel_idx = cmd_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inuse_q  <= '0;
         for (int i = 0; i < NUM_BUF; i++) cnt_q[i] <= '0;
         err_flag <= 1'b0;
      end else begin
         if (bad) err_flag <= 1'b1;
         if (good) begin
            if (cmd_op == OP_SET) cnt_q[cmd_idx] <= cmd_cnt;
            if (cmd_op == OP_DEC) cnt_q[cmd_idx] <= cnt_q[cmd_idx] - 1'b1;
         end
         if (rel_vld) inuse_q[cmd_idx] <= 1'b0;
         if (take) begin
            inuse_q[take_idx] <= 1'b1;
            cnt_q[take_idx]   <= CNT_W'(1);
         end
      end
   end

   // R2
   take_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> inuse_q[$past(take_idx)] && cnt_q[$past(take_idx)] == CNT_W'(1));
   // R4
   set_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (good && cmd_op == OP_SET && !(take && take_idx == cmd_idx))
      |=> cnt_q[$past(cmd_idx)] == $past(cmd_cnt));
   // R5
   release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_vld && !(take && take_idx == rel_idx)) |=> !inuse_q[$past(rel_idx)]);
   // R8
   bad_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bad && !take) |=> $stable(inuse_q));
   // R9
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);
endmodule

// File: rtl/pbuf_mgr.sv
module pbuf_mgr
   import pbuf_pkg::*;
#(
   parameter int NUM_BUF = 16,
   parameter int CNT_W   = 5,
   parameter bit BYPASS  = 1'b1,
   parameter int IDX_W   = $clog2(NUM_BUF)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_req,
   output logic             alloc_gnt,
   output logic [IDX_W-1:0] alloc_idx,
   output logic             alloc_nobuf,
   input  logic             cmd_vld,
   input  logic [1:0]       cmd_op,
   input  logic [IDX_W-1:0] cmd_idx,
   input  logic [CNT_W-1:0] cmd_cnt,
   output logic             err_flag
);
   if (NUM_BUF < 2) begin : g_bad_depth
      $error("pbuf_mgr: NUM_BUF must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("pbuf_mgr: CNT_W must be at least 1");
   end
   if (IDX_W < $clog2(NUM_BUF)) begin : g_bad_idx
      $error("pbuf_mgr: IDX_W too narrow for NUM_BUF");
   end

   logic             rel_vld, fifo_empty, fifo_pop, fifo_push, byp;
   logic [IDX_W-1:0] rel_idx, head_idx;

   if (BYPASS) begin : g_byp
      assign byp = alloc_req && fifo_empty && rel_vld;
   end else begin : g_nobyp
      assign byp = 1'b0;
   end

   assign fifo_pop    = alloc_req && !fifo_empty;
   assign fifo_push   = rel_vld && !byp;
   assign alloc_gnt   = fifo_pop || byp;
   assign alloc_nobuf = alloc_req && !alloc_gnt;
   assign alloc_idx   = fifo_pop ? head_idx : (byp ? rel_idx : '0);

   pbuf_free_fifo #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(fifo_push), .push_idx(rel_idx),
      .pop(fifo_pop), .head_idx(head_idx), .empty(fifo_empty)
   );

   pbuf_refcnt #(.NUM_BUF(NUM_BUF), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .cmd_vld(cmd_vld), .cmd_op(pbuf_op_e'(cmd_op)),
      .cmd_idx(cmd_idx), .cmd_cnt(cmd_cnt),
      .take(alloc_gnt), .take_idx(alloc_idx),
      .rel_vld(rel_vld), .rel_idx(rel_idx), .err_flag(err_flag)
   );

   // R3
   grant_when_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_req && !fifo_empty) |-> alloc_gnt && !alloc_nobuf);
   // R7
   bypass_hand_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (BYPASS && alloc_req && fifo_empty && rel_vld) |-> alloc_gnt && alloc_idx == rel_idx);
endmodule

// File: tb/test_pbuf_mgr.sv
module test_pbuf_mgr;
   localparam int NB = 16;
   localparam int IW = 4;
   localparam int CW = 5;

   typedef struct packed { logic g; logic n; logic [IW-1:0] i; } exp_t;

   logic clk = 0, rst_n = 0;
   logic alloc_req = 0, cmd_vld = 0;
   logic [1:0] cmd_op = 0;
   logic [IW-1:0] cmd_idx = 0;
   logic [CW-1:0] cmd_cnt = 0;
   logic alloc_gnt, alloc_nobuf, err_flag;
   logic [IW-1:0] alloc_idx;

   int n_chk = 0, n_bad = 0;
   exp_t exp_q[$];
   int   m_free[$];
   bit   m_use[NB];
   int   m_cnt[NB];
   bit   m_err;

   always #5 clk = ~clk;

   pbuf_mgr i_pbuf_mgr (
      .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_gnt(alloc_gnt),
      .alloc_idx(alloc_idx), .alloc_nobuf(alloc_nobuf), .cmd_vld(cmd_vld),
      .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_cnt(cmd_cnt), .err_flag(err_flag)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: compare grant outputs against scoreboard before each rising edge
   always begin
      @(negedge clk);
      #4;
      if (rst_n && alloc_req) begin
         exp_t e;
         if (exp_q.size() == 0) check("R2 scoreboard empty", 1, 0);
         else begin
            e = exp_q.pop_front();
            check("R2/R3/R7 alloc_gnt", alloc_gnt, e.g);
            check("R3 alloc_nobuf", alloc_nobuf, e.n);
            if (e.g) check("R1/R2/R7 alloc_idx", alloc_idx, e.i);
         end
      end else if (rst_n) begin
         check("R3 idle gnt", alloc_gnt, 0);
         check("R3 idle nobuf", alloc_nobuf, 0);
      end
   end

   task automatic model_reset();
      m_free.delete();
      for (int i = 0; i < NB; i++) begin
         m_free.push_back(i);
         m_use[i] = 0;
         m_cnt[i] = 0;
      end
      m_err = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; alloc_req = 0; cmd_vld = 0;
      model_reset();
      repeat (2) @(negedge clk);
      rst_n = 1;
      #1 check("R9 err after reset", err_flag, 0);
   endtask

   // driver: one cycle with optional allocate and command
   task automatic cyc(input bit req, input bit cv, input int op, input int idx, input int cnt);
      bit bad, rel;
      exp_t e;
      @(negedge clk);
      alloc_req = req; cmd_vld = cv; cmd_op = op[1:0];
      cmd_idx = idx[IW-1:0]; cmd_cnt = cnt[CW-1:0];
      bad = cv && op != 0 && (!m_use[idx] || (op == 1 && cnt == 0));
      rel = cv && op != 0 && !bad && (op == 3 || (op == 2 && m_cnt[idx] == 1));
      e = '0;
      if (req) begin
         if (m_free.size() > 0) begin e.g = 1; e.i = m_free[0][IW-1:0]; end
         else if (rel) begin e.g = 1; e.i = idx[IW-1:0]; end
         else e.n = 1;
         exp_q.push_back(e);
      end
      if (bad) m_err = 1;
      if (!bad && cv && op == 1) m_cnt[idx] = cnt;
      if (!bad && cv && op == 2) m_cnt[idx] = m_cnt[idx] - 1;
      if (rel) m_use[idx] = 0;
      if (req && m_free.size() > 0) void'(m_free.pop_front());
      if (rel && !(req && e.g && e.i == idx[IW-1:0] && m_free.size() == 0 &&
                   !(m_free.size() > 0)))
         ;
      if (rel) begin
         if (req && e.g && int'(e.i) == idx) ; else m_free.push_back(idx);
      end
      if (e.g) begin m_use[e.i] = 1; m_cnt[e.i] = 1; end
      @(posedge clk);
      #1 check("R8/R9 err_flag", err_flag, m_err);
      alloc_req = 0; cmd_vld = 0;
   endtask

   initial begin
      #(200000 * 10);
      check("watchdog expired", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      do_reset();
      // R1 R2: drain pool in order
      for (int k = 0; k < NB; k++) cyc(1, 0, 0, 0, 0);
      // R3: empty pool refuses
      cyc(1, 0, 0, 0, 0);
      // R6: drop frees regardless of count
      cyc(0, 1, 1, 3, 4);
      cyc(0, 1, 3, 3, 0);
      // R4 R5: fan-out of 3 on buffer 5
      cyc(0, 1, 1, 5, 3);
      cyc(0, 1, 2, 5, 0);
      cyc(0, 1, 2, 5, 0);
      cyc(1, 0, 0, 0, 0);      // gets 3
      cyc(0, 1, 2, 5, 0);      // last dest, frees 5
      cyc(0, 1, 2, 7, 0);      // unicast frees 7
      cyc(0, 1, 0, 8, 0);      // R6 none op: no effect
      cyc(1, 0, 0, 0, 0);      // 5
      cyc(1, 0, 0, 0, 0);      // 7
      cyc(1, 0, 0, 0, 0);      // R3 nobuf, 8 not freed
      // R7: bypass with empty pool
      cyc(1, 1, 3, 9, 0);
      cyc(1, 0, 0, 0, 0);
      // R8: set with zero count keeps count 1
      cyc(0, 1, 1, 2, 0);
      cyc(0, 1, 2, 2, 0);      // frees 2
      // R8: double free leaves pool unchanged
      cyc(0, 1, 3, 2, 0);
      cyc(0, 1, 2, 2, 0);
      cyc(1, 0, 0, 0, 0);      // 2
      cyc(1, 0, 0, 0, 0);      // nobuf
      // non-empty pool: alloc and free same cycle
      cyc(0, 1, 3, 10, 0);
      cyc(0, 1, 3, 11, 0);
      cyc(1, 1, 3, 12, 0);     // gets 10, 12 to tail
      cyc(1, 0, 0, 0, 0);      // 11
      cyc(1, 0, 0, 0, 0);      // 12
      // R8: command on the index granted this very cycle
      cyc(0, 1, 3, 13, 0);
      cyc(1, 1, 2, 13, 0);     // grants 13, command is an error
      cyc(1, 0, 0, 0, 0);      // nobuf
      // R9: reset clears error, R1 order restarts
      do_reset();
      for (int k = 0; k < 3; k++) cyc(1, 0, 0, 0, 0);
      repeat (3) @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule